// File: doc/BRIEF.md
# Dual-Mode Cascadable Pulse Accumulator

This block counts activity on one asynchronous input pin. In event mode it adds one for each chosen pin edge. In gated mode it adds one for each tick of the system clock divided by 64 while the pin holds an active level. The tick comes from a small prescaler that runs only while a separate timer enable is high, so gated counting stops when that enable drops. Event counting does not depend on the timer enable.

The count storage is two 8-bit bytes. With the chain control low they act as two separate counters, and each runs only when its own enable is set. With the chain control high they form one 16-bit accumulator. The upper byte is the high half, and the per-byte enables are ignored. In this mode an input-edge flag reports pin edges, and an overflow flag reports the 16-bit rollover.

A small register port loads either byte, clears the flags by writing ones, and reads back the bytes or the flags one cycle after the address is presented.

Top module: `dual_pulse_accumulator`

## Requirements
- R1: While reset is high and after it, both count bytes, both flags and the read data are zero.
- R2: In event mode (gate_mode=0) with polarity=1 each rising pin edge adds one, and with polarity=0 each falling edge adds one; edges of the other direction add nothing. The pin passes a two-flop synchronizer, so the count changes on the third rising clock edge after the pin changes.
- R3: In gated mode (gate_mode=1) the count adds one per prescaler tick while the pin is at the active level (high when polarity=0, low when polarity=1). The prescaler gives one tick every 64 clocks, so an active window of 64*k clocks adds exactly k. The inactive level adds nothing.
- R4: With timer_en=0 gated mode does not advance, while event mode still counts.
- R5: With sys_en=0 the low byte counts only when lo_en=1 and the high byte only when hi_en=1. Each byte wraps from 0xFF to 0x00 on its own, with no carry and no overflow flag.
- R6: With sys_en=1 the bytes form one 16-bit count {cnt_hi, cnt_lo} that steps by one per increment, carrying into the high byte, whatever lo_en and hi_en are.
- R7: edge_flag is set only while sys_en=1. It is set by the active edge in event mode and by the trailing edge in gated mode (a falling edge when polarity=0, a rising edge when polarity=1).
- R8: With sys_en=1 a step from 0xFFFF to 0x0000 sets ovf_flag.
- R9: Flags are in the flag register (address 2): bit 0 is edge_flag and bit 1 is ovf_flag. Writing 1 to a bit clears it and writing 0 leaves it. If a set and a clear occur in the same cycle, the set wins.
- R10: A write to address 0 loads cnt_hi and a write to address 1 loads cnt_lo. A byte write in the same cycle as an increment wins, and that increment is dropped.
- R11: reg_rdata returns cnt_hi for address 0, cnt_lo for address 1, the flag register (upper six bits zero) for address 2 and zero for address 3, one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous count input |
| timer_en | input | 1 | Runs the divide-by-64 prescaler |
| sys_en | input | 1 | Chains the bytes into 16 bits and enables edge flag |
| gate_mode | input | 1 | 0 event counting, 1 gated time accumulation |
| polarity | input | 1 | Edge select (event) or gate level and trailing edge (gated) |
| lo_en | input | 1 | Low byte enable when not chained |
| hi_en | input | 1 | High byte enable when not chained |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_hi | output | 8 | Upper count byte |
| cnt_lo | output | 8 | Lower count byte |
| edge_flag | output | 1 | Input-edge flag |
| ovf_flag | output | 1 | 16-bit rollover flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 6-bit prescaler and a two-stage synchronizer. With a 64-clock tick, gated windows of 128 and 256 clocks give exact expected counts whatever the prescaler phase is. The synchronizer latency of the two-stage chain is short enough to check edge by edge, which also makes it possible to line up a register write with an increment in the same cycle. With 8-bit bytes, the byte wrap and the 16-bit rollover are reached after a few pulses by preloading values near the limit.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
  localparam int unsigned FLAG_EDGE_BIT = 0;
  localparam int unsigned FLAG_OVF_BIT  = 1;

  typedef struct packed {
    logic chain;
    logic gated;
    logic pol;
    logic lo_on;
    logic hi_on;
  } pacc_cfg_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
  parameter int unsigned BITS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam logic [BITS-1:0] STEP = 1;
  logic [BITS-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)      div_q <= '0;
    else if (run) div_q <= div_q + STEP;
  end

  assign tick = run & (&div_q);
endmodule

// File: rtl/pacc_core.sv
module pacc_core
  import pacc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pacc_cfg_t         cfg,
  input  logic              inc,
  input  logic              flag_set,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      hi_q,
  output logic [W-1:0]      lo_q,
  output logic              edge_q,
  output logic              ovf_q
);
  localparam logic [W-1:0] ONE = 1;

  logic wr_hi, wr_lo, wr_flag, bump, bump_lo, bump_hi, roll;

  assign wr_hi   = wr && (addr == ADDR_HI);
  assign wr_lo   = wr && (addr == ADDR_LO);
  assign wr_flag = wr && (addr == ADDR_FLAG);

  // a byte load drops the increment of that cycle for both bytes
  assign bump    = inc && !(wr_hi || wr_lo);
  assign bump_lo = bump && (cfg.chain || cfg.lo_on);
  assign bump_hi = bump && (cfg.chain ? (&lo_q) : cfg.hi_on);
  assign roll    = bump && cfg.chain && (&lo_q) && (&hi_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_hi)        hi_q <= wdata;
      else if (bump_hi) hi_q <= hi_q + ONE;

      if (wr_lo)        lo_q <= wdata;
      else if (bump_lo) lo_q <= lo_q + ONE;

      if (flag_set)                           edge_q <= 1'b1;
      else if (wr_flag && wdata[FLAG_EDGE_BIT]) edge_q <= 1'b0;

      if (roll)                               ovf_q <= 1'b1;
      else if (wr_flag && wdata[FLAG_OVF_BIT])  ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_pulse_accumulator.sv
module dual_pulse_accumulator
  import pacc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_BITS    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              timer_en,
  input  logic              sys_en,
  input  logic              gate_mode,
  input  logic              polarity,
  input  logic              lo_en,
  input  logic              hi_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [CNT_W-1:0]  cnt_hi,
  output logic [CNT_W-1:0]  cnt_lo,
  output logic              edge_flag,
  output logic              ovf_flag
);
  pacc_cfg_t cfg;
  logic pin_lvl, pin_rise, pin_fall, tick;
  logic sel_edge, gate_open, inc, flag_set;

  assign cfg = '{chain: sys_en, gated: gate_mode, pol: polarity,
                 lo_on: lo_en, hi_on: hi_en};

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  pacc_prescaler #(.BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst(rst), .run(timer_en), .tick(tick)
  );

  // the chosen edge is the counted edge in event mode and the
  // trailing edge of the gate window in gated mode
  assign sel_edge  = cfg.pol ? pin_rise : pin_fall;
  assign gate_open = cfg.pol ? ~pin_lvl : pin_lvl;
  assign inc       = cfg.gated ? (gate_open & tick) : sel_edge;
  assign flag_set  = cfg.chain & sel_edge;

  pacc_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cfg(cfg), .inc(inc), .flag_set(flag_set),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hi_q(cnt_hi), .lo_q(cnt_lo), .edge_q(edge_flag), .ovf_q(ovf_flag)
  );

  logic [CNT_W-1:0] flag_word;
  always_comb begin
    flag_word = '0;
    flag_word[FLAG_EDGE_BIT] = edge_flag;
    flag_word[FLAG_OVF_BIT]  = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        ADDR_HI:   reg_rdata <= cnt_hi;
        ADDR_LO:   reg_rdata <= cnt_lo;
        ADDR_FLAG: reg_rdata <= flag_word;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
  import pacc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              timer_en,
  input logic              sys_en,
  input logic              gate_mode,
  input logic              lo_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      cnt_hi,
  input logic [W-1:0]      cnt_lo,
  input logic              edge_flag,
  input logic              ovf_flag
);
  localparam logic [2*W-1:0] ONE2 = 1;

  assert_gate_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (gate_mode && !timer_en && !reg_wr) |=> $stable({cnt_hi, cnt_lo}));

  assert_lo_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!sys_en && !lo_en && !reg_wr) |=> $stable(cnt_lo));

  assert_cascade_step_R6: assert property (@(posedge clk) disable iff (rst)
    (sys_en && !reg_wr) |=> (({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo})) ||
                             ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + ONE2)));

  assert_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> !$rose(edge_flag));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ({cnt_hi, cnt_lo} == '0));

  assert_load_lo_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_LO) |=> (cnt_lo == $past(reg_wdata)));

  assert_read_hi_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_HI) |=> (reg_rdata == $past(cnt_hi)));
endmodule

bind dual_pulse_accumulator pacc_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .timer_en(timer_en), .sys_en(sys_en),
  .gate_mode(gate_mode), .lo_en(lo_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .edge_flag(edge_flag),
  .ovf_flag(ovf_flag)
);

// File: tb/dual_pulse_accumulator_test.sv
`timescale 1ns/1ps
module dual_pulse_accumulator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_in = 1'b0, timer_en = 1'b0, sys_en = 1'b0, gate_mode = 1'b0;
  logic polarity = 1'b0, lo_en = 1'b0, hi_en = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata, cnt_hi, cnt_lo;
  logic edge_flag, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_pulse_accumulator uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .timer_en(timer_en),
    .sys_en(sys_en), .gate_mode(gate_mode), .polarity(polarity),
    .lo_en(lo_en), .hi_en(hi_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_hi(cnt_hi),
    .cnt_lo(cnt_lo), .edge_flag(edge_flag), .ovf_flag(ovf_flag)
  );

  // {sys, pol, lo_en, hi_en, preload[15:0], pulses[3:0], expect[15:0], edge, ovf}
  localparam int NVEC = 7;
  localparam logic [41:0] VEC [NVEC] = '{
    {4'b1000, 16'h0000, 4'd3, 16'h0003, 1'b1, 1'b0},
    {4'b1111, 16'h00FE, 4'd3, 16'h0101, 1'b1, 1'b0},
    {4'b0110, 16'h05FE, 4'd3, 16'h0501, 1'b0, 1'b0},
    {4'b0001, 16'hFF10, 4'd2, 16'h0110, 1'b0, 1'b0},
    {4'b0111, 16'h20FF, 4'd1, 16'h2100, 1'b0, 1'b0},
    {4'b1000, 16'hFFFE, 4'd2, 16'h0000, 1'b1, 1'b1},
    {4'b0100, 16'h1234, 4'd2, 16'h1234, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    step(1);
    d = reg_rdata;
  endtask

  task automatic pulse();
    pin_in = 1'b1; step(4);
    pin_in = 1'b0; step(4);
  endtask

  initial begin
    #(50000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    step(3);
    check("R1 hi after reset", cnt_hi, 0);
    check("R1 lo after reset", cnt_lo, 0);
    check("R1 flags after reset", {edge_flag, ovf_flag}, 0);
    check("R1 rdata after reset", reg_rdata, 0);
    rst = 1'b0;
    step(2);

    // table: event mode, timer off (R2 R4 R5 R6 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v = VEC[i];
      sys_en = v[41]; polarity = v[40]; lo_en = v[39]; hi_en = v[38];
      gate_mode = 1'b0; timer_en = 1'b0;
      step(2);
      wr(2'd0, v[37:30]);
      wr(2'd1, v[29:22]);
      wr(2'd2, 8'h03);
      for (int p = 0; p < int'(v[21:18]); p++) pulse();
      step(4);
      check($sformatf("R2 R5 R6 count vec%0d", i), {cnt_hi, cnt_lo}, v[17:2]);
      check($sformatf("R7 edge vec%0d", i), edge_flag, v[1]);
      check($sformatf("R8 ovf vec%0d", i), ovf_flag, v[0]);
    end

    // R2 synchronizer latency, rising edge
    sys_en = 1'b1; polarity = 1'b1; gate_mode = 1'b0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    pin_in = 1'b1; step(2);
    check("R2 not yet after two edges", cnt_lo, 8'h00);
    step(1);
    check("R2 counted on third edge", cnt_lo, 8'h01);
    pin_in = 1'b0; step(4);
    check("R2 falling edge ignored when polarity=1", cnt_lo, 8'h01);

    // R10 write beats increment in same cycle
    pin_in = 1'b1; step(2);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h55;
    step(1);
    reg_wr = 1'b0;
    check("R10 write wins lo", cnt_lo, 8'h55);
    check("R10 write wins hi", cnt_hi, 8'h00);
    pin_in = 1'b0; step(4);

    // R9 set wins over clear; write-0 no effect; write-1 clears
    wr(2'd2, 8'h03);
    check("R9 cleared", edge_flag, 1'b0);
    pin_in = 1'b1; step(2);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    step(1);
    reg_wr = 1'b0;
    check("R9 set wins over clear", edge_flag, 1'b1);
    pin_in = 1'b0; step(4);
    wr(2'd2, 8'h00);
    check("R9 write zero keeps flag", edge_flag, 1'b1);
    wr(2'd2, 8'h01);
    check("R9 write one clears", edge_flag, 1'b0);

    // R11 readback
    rd(2'd0, r); check("R11 read hi", r, 8'h00);
    rd(2'd1, r); check("R11 read lo", r, 8'h56);
    rd(2'd2, r); check("R11 read flags", r, 8'h00);
    rd(2'd3, r); check("R11 read unused", r, 8'h00);

    // R3 gated, polarity 0: 256 high clocks give 4
    gate_mode = 1'b1; polarity = 1'b0; timer_en = 1'b1;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    pin_in = 1'b1; step(256);
    pin_in = 1'b0; step(8);
    check("R3 gated high window", {cnt_hi, cnt_lo}, 16'h0004);
    check("R7 trailing fall sets flag", edge_flag, 1'b1);
    step(100);
    check("R3 inactive level holds", {cnt_hi, cnt_lo}, 16'h0004);

    // R3 gated, polarity 1: 128 low clocks give 2
    timer_en = 1'b0; pin_in = 1'b1; polarity = 1'b1; step(4);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    timer_en = 1'b1; step(3);
    pin_in = 1'b0; step(128);
    pin_in = 1'b1; step(8);
    timer_en = 1'b0;
    check("R3 gated low window", {cnt_hi, cnt_lo}, 16'h0002);
    check("R7 trailing rise sets flag", edge_flag, 1'b1);

    // R4 gated with timer off does not advance
    polarity = 1'b0; pin_in = 1'b0; step(4);
    pin_in = 1'b1; step(300);
    pin_in = 1'b0; step(8);
    check("R4 gated idle without timer", {cnt_hi, cnt_lo}, 16'h0002);

    // R8 rollover and flag register view (R9 R11)
    gate_mode = 1'b0; polarity = 1'b1;
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'h03);
    pulse(); step(2);
    check("R8 wrap to zero", {cnt_hi, cnt_lo}, 16'h0000);
    check("R8 overflow set", ovf_flag, 1'b1);
    rd(2'd2, r); check("R11 flags both set", r, 8'h03);
    wr(2'd2, 8'h02);
    rd(2'd2, r); check("R9 clear only overflow", r, 8'h01);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule